// File: doc/BRIEF.md
# Serial Command Front End for a Two-Channel Digital Potentiometer

This block is the serial slave that sits in front of the register bank of a two-channel digital potentiometer. A host drives chip select, serial clock, serial data in and a pause line, all in SPI mode 0: data in is taken on the rising clock edge and data out changes on the falling edge. The pins are oversampled by the system clock through a synchronizer, so every frame decision is made in one clock domain.

Each frame opens with an identification byte that carries a four-bit device type and two address bits, which must match the strap pins. The next byte carries an opcode, a register slot select and a channel select. Depending on the opcode, the frame ends after that byte, takes a third byte of data in or out, or runs open-ended as a stream of single-step wiper moves. Completed commands that change state leave the block as single-cycle strobes with their fields. Read commands shift back a byte built from the bank's read data or its busy flag. The pause line freezes a frame at its current bit until released.

Top module: `pot_spi_cmd_front`

## Requirements
- R1: After reset, `op_valid_o` and `so_oe_o` are low, and no frame starts until chip select has been seen high and then low; bytes clocked while chip select has been low since reset cause no strobe and no output drive.
- R2: The first byte of a frame is accepted only if bits 7:4 equal 0101, bits 3:2 equal `addr_strap_i` and bits 1:0 are 00; otherwise the rest of the frame is ignored until chip select rises.
- R3: The second byte is decoded as opcode in bits 7:4, slot select in bits 3:2, a pad in bit 1 and channel select in bit 0; `op_code_o`, `op_reg_o` and `op_pot_o` carry these fields with every strobe.
- R4: Opcodes 1101, 1110, 0001 and 1000 are two-byte commands and give one strobe once the 16th bit has been taken.
- R5: Opcodes 1010 and 1100 take a third byte and give one strobe once the 24th bit has been taken, with `op_data_o` equal to bits 5:0 of that byte; bits 7:6 of it are ignored.
- R6: For opcodes 1001 and 1011, the third byte on `so_o` is 00 followed by `rd_data_i`, MSB first, the first bit appearing after the 16th falling clock edge and each later bit after the next falling edge; SI is ignored during that byte and no strobe is issued.
- R7: For opcode 0101, the byte on `so_o` carries `wip_i` in bit 0 and zeros in bits 7:1.
- R8: After opcode 0010, every further rising clock edge in the frame gives one strobe with `op_code_o` = 0010 and `op_dir_o` equal to SI at that edge (1 steps toward the high end, 0 toward the low end).
- R9: A frame whose chip select rises before its required length is complete gives no strobe.
- R10: An opcode outside the ten listed, or an instruction byte with bit 1 set, gives no strobe and no output drive for the rest of the frame.
- R11: `so_oe_o` is low whenever chip select is high and during frames that return no data; `so_o` changes only after a detected falling clock edge.
- R12: Pulling the pause line low while the serial clock is low freezes the frame and drops `so_oe_o`; clock edges during the pause are ignored; raising it while the clock is low resumes at the same bit.
- R13: Bits clocked after a fixed-length command has completed are ignored and give no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the host |
| si_i | input | 1 | Serial data from the host |
| hold_n_i | input | 1 | Pause line, active low |
| addr_strap_i | input | ADDR_W | Strap address compared with the first byte |
| rd_data_i | input | DATA_W | Read data from the register bank for the selected register |
| wip_i | input | 1 | Busy flag from the register bank |
| so_o | output | 1 | Serial data to the host |
| so_oe_o | output | 1 | Output enable for the serial data pad |
| op_valid_o | output | 1 | Single-cycle command strobe to the register bank |
| op_code_o | output | 4 | Opcode of the last decoded instruction |
| op_pot_o | output | 1 | Channel select of the last decoded instruction |
| op_reg_o | output | REG_W | Slot select of the last decoded instruction |
| op_data_o | output | DATA_W | Data payload of the last write strobe |
| op_dir_o | output | 1 | Step direction of the last step strobe |

## Verification
The decoder is driven with one frame per opcode class: two-byte transfers with every slot and both channels, writes whose data byte has its top bits set, reads of both register kinds and busy reads with the flag at both values; these separate length handling, field extraction and the response byte. Frames with a wrong type, wrong address, nonzero pad bits or an unused opcode show whether rejection holds for the whole frame. Truncated frames, trailing bits, a step stream with mixed directions, a frame sent without a fresh chip select after reset, and frames paused mid-byte with extra clock pulses show whether strobes depend on completed length, edge counting and the frozen bit position.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int BYTE_W = 8;
  localparam int OPC_W  = 4;

  typedef enum logic [3:0] {
    OPC_GLB_TO_WIPER   = 4'b0001,
    OPC_STEP           = 4'b0010,
    OPC_STATUS         = 4'b0101,
    OPC_GLB_TO_STORE   = 4'b1000,
    OPC_RD_WIPER       = 4'b1001,
    OPC_WR_WIPER       = 4'b1010,
    OPC_RD_STORE       = 4'b1011,
    OPC_WR_STORE       = 4'b1100,
    OPC_STORE_TO_WIPER = 4'b1101,
    OPC_WIPER_TO_STORE = 4'b1110
  } opc_e;

  // Length / behaviour class of a decoded instruction
  typedef enum logic [2:0] {
    CL_BAD,
    CL_SHORT,
    CL_WRITE,
    CL_READ,
    CL_STATUS,
    CL_STEP
  } cls_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_INSTR,
    ST_DATA,
    ST_STEP
  } st_e;
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pcd_rx.sv
module pcd_rx #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o
);
  logic [BYTE_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (shift_i) begin
      sreg <= byte_o;
      cnt  <= (cnt == CNT_W'(BYTE_W-1)) ? '0 : cnt + 1'b1;
    end
  end

  // byte including the bit arriving on this edge
  assign byte_o = {sreg[BYTE_W-2:0], bit_i};
  assign cnt_o  = cnt;
  assign done_o = shift_i && (cnt == CNT_W'(BYTE_W-1));
endmodule

// File: rtl/pcd_decode.sv
module pcd_decode
  import pcd_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic             pad_zero_i,
  output cls_e             cls_o
);
  always_comb begin
    cls_o = CL_BAD;
    if (pad_zero_i) begin
      case (opc_i)
        OPC_STORE_TO_WIPER, OPC_WIPER_TO_STORE,
        OPC_GLB_TO_WIPER,   OPC_GLB_TO_STORE:   cls_o = CL_SHORT;
        OPC_WR_WIPER,       OPC_WR_STORE:       cls_o = CL_WRITE;
        OPC_RD_WIPER,       OPC_RD_STORE:       cls_o = CL_READ;
        OPC_STATUS:                             cls_o = CL_STATUS;
        OPC_STEP:                               cls_o = CL_STEP;
        default:                                cls_o = CL_BAD;
      endcase
    end
  end
endmodule

// File: rtl/pcd_tx.sv
module pcd_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic              so_o
);
  logic [BYTE_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)          sreg <= '0;
    else if (load_i)  sreg <= din_i;
    else if (shift_i) sreg <= {sreg[BYTE_W-2:0], 1'b0};
  end

  assign so_o = sreg[BYTE_W-1];
endmodule

// File: rtl/pot_spi_cmd_front.sv
module pot_spi_cmd_front
  import pcd_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               ADDR_W      = 2,
  parameter int               REG_W       = 2,
  parameter int               DATA_W      = 6,
  parameter logic [OPC_W-1:0] DEV_TYPE    = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              hold_n_i,
  input  logic [ADDR_W-1:0] addr_strap_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              wip_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              op_valid_o,
  output logic [OPC_W-1:0]  op_code_o,
  output logic              op_pot_o,
  output logic [REG_W-1:0]  op_reg_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              op_dir_o
);
  localparam int CNT_W    = $clog2(BYTE_W);
  localparam int OPC_LSB  = BYTE_W - OPC_W;
  localparam int ADDR_LSB = OPC_LSB - ADDR_W;
  localparam int REG_LSB  = OPC_LSB - REG_W;

  // ---------------- pin synchronizer: {cs, sck, si, hold}
  logic [3:0] pins_q;
  logic cs_q, sck_q, si_q, hold_q;

  // chip select resets to "selected" so a frame needs a real high-to-low
  pcd_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cs_n_i, sck_i, si_i, hold_n_i}),
    .q_o (pins_q)
  );
  assign {cs_q, sck_q, si_q, hold_q} = pins_q;

  // ---------------- edge detection and pause
  logic cs_prev, sck_prev, paused_q;
  logic cs_fall, live, sck_rise, sck_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev  <= 1'b0;
      sck_prev <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      cs_prev  <= cs_q;
      sck_prev <= sck_q;
      if (cs_q)        paused_q <= 1'b0;
      else if (!sck_q) paused_q <= !hold_q;
    end
  end

  assign cs_fall  = cs_prev && !cs_q;
  assign live     = !cs_q && !paused_q;
  assign sck_rise = live && sck_q && !sck_prev;
  assign sck_fall = live && !sck_q && sck_prev;

  // ---------------- receive shifter
  st_e               state_q;
  cls_e              cls_q, cls_d;
  logic [BYTE_W-1:0] rx_byte;
  logic [CNT_W-1:0]  rx_cnt;
  logic              rx_done, rx_shift;

  assign rx_shift = sck_rise &&
                    (state_q == ST_ID || state_q == ST_INSTR || state_q == ST_DATA);

  pcd_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (cs_fall || cs_q),
    .shift_i (rx_shift),
    .bit_i   (si_q),
    .byte_o  (rx_byte),
    .cnt_o   (rx_cnt),
    .done_o  (rx_done)
  );

  // ---------------- byte checks
  logic id_ok;
  assign id_ok = (rx_byte[BYTE_W-1 -: OPC_W]   == DEV_TYPE) &&
                 (rx_byte[OPC_LSB-1 -: ADDR_W] == addr_strap_i) &&
                 (rx_byte[ADDR_LSB-1:0]        == '0);

  pcd_decode u_dec (
    .opc_i      (rx_byte[BYTE_W-1 -: OPC_W]),
    .pad_zero_i (rx_byte[REG_LSB-1:1] == '0),
    .cls_o      (cls_d)
  );

  // ---------------- frame sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cls_q      <= CL_BAD;
      op_valid_o <= 1'b0;
      op_code_o  <= '0;
      op_pot_o   <= 1'b0;
      op_reg_o   <= '0;
      op_data_o  <= '0;
      op_dir_o   <= 1'b0;
    end else begin
      op_valid_o <= 1'b0;
      if (cs_q) begin
        state_q <= ST_IDLE;
      end else if (cs_fall) begin
        state_q <= ST_ID;
      end else if (sck_rise) begin
        case (state_q)
          ST_ID: if (rx_done) state_q <= id_ok ? ST_INSTR : ST_IDLE;
          ST_INSTR: if (rx_done) begin
            op_code_o <= rx_byte[BYTE_W-1 -: OPC_W];
            op_reg_o  <= rx_byte[REG_LSB +: REG_W];
            op_pot_o  <= rx_byte[0];
            cls_q     <= cls_d;
            case (cls_d)
              CL_SHORT: begin
                op_valid_o <= 1'b1;
                state_q    <= ST_IDLE;
              end
              CL_WRITE, CL_READ, CL_STATUS: state_q <= ST_DATA;
              CL_STEP:                      state_q <= ST_STEP;
              default:                      state_q <= ST_IDLE;
            endcase
          end
          ST_DATA: if (rx_done) begin
            if (cls_q == CL_WRITE) begin
              op_valid_o <= 1'b1;
              op_data_o  <= rx_byte[DATA_W-1:0];
            end
            state_q <= ST_IDLE;
          end
          ST_STEP: begin
            op_valid_o <= 1'b1;
            op_dir_o   <= si_q;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // ---------------- transmit path
  logic              resp_frame, tx_live, tx_load, tx_shift;
  logic [BYTE_W-1:0] resp_byte;

  assign resp_frame = (state_q == ST_DATA) &&
                      (cls_q == CL_READ || cls_q == CL_STATUS);
  assign tx_load    = sck_fall && resp_frame && !tx_live && (rx_cnt == '0);
  assign tx_shift   = sck_fall && resp_frame && tx_live;
  assign resp_byte  = (cls_q == CL_STATUS) ? BYTE_W'(wip_i) : BYTE_W'(rd_data_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_live <= 1'b0;
      so_oe_o <= 1'b0;
    end else begin
      if (cs_q || state_q != ST_DATA) tx_live <= 1'b0;
      else if (tx_load)               tx_live <= 1'b1;
      so_oe_o <= tx_live && !paused_q && !cs_q && (state_q == ST_DATA);
    end
  end

  pcd_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .load_i  (tx_load),
    .shift_i (tx_shift),
    .din_i   (resp_byte),
    .so_o    (so_o)
  );
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker
  import pcd_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_q,
  input logic             paused_q,
  input logic             sck_fall,
  input logic             so_o,
  input logic             so_oe_o,
  input logic             op_valid_o,
  input logic [OPC_W-1:0] op_code_o,
  input st_e              state_q,
  input logic [CNT_W-1:0] rx_cnt
);
  assert_quiet_deselected_R11: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !so_oe_o);

  assert_so_moves_on_fall_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(so_o) |-> $past(sck_fall));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    op_valid_o |=> !op_valid_o);

  assert_strobe_legal_code_R10: assert property (@(posedge clk) disable iff (rst)
    op_valid_o |-> (op_code_o == OPC_STORE_TO_WIPER || op_code_o == OPC_WIPER_TO_STORE ||
                    op_code_o == OPC_GLB_TO_WIPER   || op_code_o == OPC_GLB_TO_STORE   ||
                    op_code_o == OPC_WR_WIPER       || op_code_o == OPC_WR_STORE       ||
                    op_code_o == OPC_STEP));

  assert_strobe_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
    op_valid_o |-> (!$past(cs_q) &&
                    ($past(state_q) == ST_INSTR || $past(state_q) == ST_DATA ||
                     $past(state_q) == ST_STEP)));

  assert_pause_freezes_R12: assert property (@(posedge clk) disable iff (rst)
    (paused_q && $past(paused_q)) |-> ($stable(state_q) && $stable(rx_cnt)));

  assert_pause_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    paused_q |=> !so_oe_o);
endmodule

bind pot_spi_cmd_front pcd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_q       (cs_q),
  .paused_q   (paused_q),
  .sck_fall   (sck_fall),
  .so_o       (so_o),
  .so_oe_o    (so_oe_o),
  .op_valid_o (op_valid_o),
  .op_code_o  (op_code_o),
  .state_q    (state_q),
  .rx_cnt     (rx_cnt)
);

// File: tb/test_pot_spi_cmd_front.sv
`timescale 1ns/1ps
module test_pot_spi_cmd_front;
  localparam int HALF = 8;
  localparam int WDOG = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [5:0] rd_data;
  logic       wip = 1'b0;
  logic       so, so_oe, op_valid, op_pot, op_dir;
  logic [3:0] op_code;
  logic [1:0] op_reg;
  logic [5:0] op_data;

  always #5 clk = ~clk;

  // register bank model: read data derived from the selected fields
  assign rd_data = {1'b1, op_pot, op_reg, op_code[1:0]};

  pot_spi_cmd_front i_pot_spi_cmd_front (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .si_i(si), .hold_n_i(hold_n),
    .addr_strap_i(strap), .rd_data_i(rd_data), .wip_i(wip),
    .so_o(so), .so_oe_o(so_oe), .op_valid_o(op_valid), .op_code_o(op_code),
    .op_pot_o(op_pot), .op_reg_o(op_reg), .op_data_o(op_data), .op_dir_o(op_dir)
  );

  int n_chk = 0, n_bad = 0;
  int stb_cnt = 0;
  logic so_seen = 1'b0;
  logic [7:0] cap_dirs = '0;

  always @(negedge clk) begin
    if (so_oe) so_seen = 1'b1;
    if (op_valid) begin
      stb_cnt++;
      cap_dirs = {cap_dirs[6:0], op_dir};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    si = b;
    wait_half();
    r = so;
    sck = 1'b1;
    wait_half();
    sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      spi_bit(b[i], r);
      rx[i] = r;
    end
  endtask

  task automatic frame_open();
    stb_cnt = 0; so_seen = 1'b0; cap_dirs = '0;
    cs_n = 1'b0;
    wait_half();
  endtask

  task automatic frame_close();
    wait_half();
    cs_n = 1'b1;
    wait_half(); wait_half();
  endtask

  task automatic spi_frame(input logic [7:0] b0, b1, b2, input int nb, output logic [7:0] rx3);
    logic [7:0] d;
    rx3 = '0;
    frame_open();
    spi_byte(b0, d);
    if (nb > 1) spi_byte(b1, d);
    if (nb > 2) spi_byte(b2, rx3);
    frame_close();
  endtask

  // third byte split by a pause after three bits, with stray clocks inside it
  task automatic hold_frame(input logic [7:0] b0, b1, b2,
                            output logic [7:0] rx3, output logic oe_mid);
    logic [7:0] d;
    logic r;
    frame_open();
    spi_byte(b0, d);
    spi_byte(b1, d);
    for (int i = 7; i >= 5; i--) begin spi_bit(b2[i], r); rx3[i] = r; end
    hold_n = 1'b0;
    wait_half(); wait_half();
    si = 1'b1;
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1; wait_half(); sck = 1'b0; wait_half();
    end
    oe_mid = so_oe;
    hold_n = 1'b1;
    wait_half();
    for (int i = 4; i >= 0; i--) begin spi_bit(b2[i], r); rx3[i] = r; end
    frame_close();
  endtask

  typedef struct packed {
    logic [7:0] b0, b1, b2;
    logic [1:0] nb;
    logic       wip;
    logic       stb;
    logic [3:0] code;
    logic       pot;
    logic [1:0] rsel;
    logic [5:0] dat;
    logic       rd;
    logic [7:0] so_exp;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'h58, 8'hD9, 8'h00, 2'd2, 1'b0, 1'b1, 4'hD, 1'b1, 2'd2, 6'h00, 1'b0, 8'h00, 4'd4},  // R4
    '{8'h58, 8'hE4, 8'h00, 2'd2, 1'b0, 1'b1, 4'hE, 1'b0, 2'd1, 6'h00, 1'b0, 8'h00, 4'd4},  // R4
    '{8'h58, 8'h1C, 8'h00, 2'd2, 1'b0, 1'b1, 4'h1, 1'b0, 2'd3, 6'h00, 1'b0, 8'h00, 4'd4},  // R4
    '{8'h58, 8'h80, 8'h00, 2'd2, 1'b0, 1'b1, 4'h8, 1'b0, 2'd0, 6'h00, 1'b0, 8'h00, 4'd4},  // R4
    '{8'h58, 8'hA1, 8'h2B, 2'd3, 1'b0, 1'b1, 4'hA, 1'b1, 2'd0, 6'h2B, 1'b0, 8'h00, 4'd5},  // R5
    '{8'h58, 8'hCD, 8'hFF, 2'd3, 1'b0, 1'b1, 4'hC, 1'b1, 2'd3, 6'h3F, 1'b0, 8'h00, 4'd5},  // R5
    '{8'h58, 8'h91, 8'hA5, 2'd3, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 6'h00, 1'b1, 8'h31, 4'd6},  // R6
    '{8'h58, 8'hB8, 8'h00, 2'd3, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 6'h00, 1'b1, 8'h2B, 4'd6},  // R6
    '{8'h58, 8'h50, 8'h00, 2'd3, 1'b1, 1'b0, 4'h0, 1'b0, 2'd0, 6'h00, 1'b1, 8'h01, 4'd7},  // R7
    '{8'h58, 8'h51, 8'hFF, 2'd3, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 6'h00, 1'b1, 8'h00, 4'd7},  // R7
    '{8'h54, 8'hD9, 8'h00, 2'd2, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 6'h00, 1'b0, 8'h00, 4'd2},  // R2
    '{8'h68, 8'hA1, 8'h2B, 2'd3, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 6'h00, 1'b0, 8'h00, 4'd2},  // R2
    '{8'h59, 8'hD9, 8'h00, 2'd2, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 6'h00, 1'b0, 8'h00, 4'd2},  // R2
    '{8'h58, 8'h30, 8'h00, 2'd3, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 6'h00, 1'b0, 8'h00, 4'd10}, // R10
    '{8'h58, 8'hD3, 8'h00, 2'd2, 1'b0, 1'b0, 4'h0, 1'b0, 2'd0, 6'h00, 1'b0, 8'h00, 4'd10}  // R10
  };

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rx3, d;
    logic oe_mid;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state, then a frame without a fresh chip select edge
    chk("R1 strobe after reset", op_valid, 1'b0);
    chk("R1 so_oe after reset", so_oe, 1'b0);
    stb_cnt = 0; so_seen = 1'b0;
    spi_byte(8'h58, d); spi_byte(8'hA1, d); spi_byte(8'h2B, d);
    chk("R1 no strobe without select edge", stb_cnt, 0);
    spi_byte(8'h58, d); spi_byte(8'h91, d); spi_byte(8'h00, d);
    chk("R1 no drive without select edge", so_seen, 1'b0);
    cs_n = 1'b1;
    wait_half(); wait_half();

    // table walk
    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[v].tag, v);
      wip = VECS[v].wip;
      spi_frame(VECS[v].b0, VECS[v].b1, VECS[v].b2, int'(VECS[v].nb), rx3);
      chk(tg, stb_cnt, VECS[v].stb ? 1 : 0);
      if (VECS[v].stb) begin
        chk(tg, op_code, VECS[v].code);
        chk("R3 channel field", op_pot, VECS[v].pot);
        chk("R3 slot field", op_reg, VECS[v].rsel);
        if (VECS[v].nb == 2'd3) chk(tg, op_data, VECS[v].dat);
      end
      chk({"R11 drive ", tg}, so_seen, VECS[v].rd);
      if (VECS[v].rd) chk(tg, rx3, VECS[v].so_exp);
      chk("R11 so_oe with select high", so_oe, 1'b0);
    end

    // R9: truncated write and truncated transfer
    frame_open();
    spi_byte(8'h58, d); spi_byte(8'hA1, d);
    for (int i = 0; i < 5; i++) begin logic r; spi_bit(1'b1, r); end
    frame_close();
    chk("R9 truncated write", stb_cnt, 0);
    frame_open();
    spi_byte(8'h58, d);
    for (int i = 0; i < 4; i++) begin logic r; spi_bit(1'b1, r); end
    frame_close();
    chk("R9 truncated transfer", stb_cnt, 0);

    // R13: trailing byte after a two-byte command
    spi_frame(8'h58, 8'hD9, 8'hA5, 3, rx3);
    chk("R13 single strobe with trailing bits", stb_cnt, 1);

    // R8: step stream 1,1,0,1 on channel 1
    frame_open();
    spi_byte(8'h58, d); spi_byte(8'h21, d);
    begin logic r; spi_bit(1'b1, r); spi_bit(1'b1, r); spi_bit(1'b0, r); spi_bit(1'b1, r); end
    frame_close();
    chk("R8 step count", stb_cnt, 4);
    chk("R8 step directions", cap_dirs[3:0], 4'b1101);
    chk("R8 step code", op_code, 4'h2);
    chk("R8 step channel", op_pot, 1'b1);

    // R12: pause in a read and in a write
    hold_frame(8'h58, 8'h91, 8'h00, rx3, oe_mid);
    chk("R12 read resumes at same bit", rx3, 8'h31);
    chk("R12 output released in pause", oe_mid, 1'b0);
    hold_frame(8'h58, 8'hA1, 8'h2B, rx3, oe_mid);
    chk("R12 write strobes once", stb_cnt, 1);
    chk("R12 write data intact", op_data, 6'h2B);

    finish_run();
  end
endmodule